// File: doc/BRIEF.md
# USB Wrapper Interrupt Aggregator

This block sits between a USB dual-role controller core and the system register bus. It collects the core's per-endpoint transmit and receive event pulses and its general core event pulses into two sticky status words, each with its own enable mask, and combines the enabled pending bits into one level interrupt line toward the processor. Software acknowledges individual events by writing ones to the status words. It re-opens the interrupt path by writing the end-of-interrupt register. Once the line has asserted, no new assertion can occur until that write arrives.

Next to the interrupt logic the block holds a few configuration registers that the controller core needs. These are a nonzero revision constant, a self-clearing soft-reset pulse for the core, a PHY/UTMI control word whose bit 21 disables OTG operation, a general mode word, and a read-only view of the live VBUS-drive level. Software reaches everything over a simple 32-bit register bus: select, write flag, byte address, write data, and combinational read data.

Top module: `usbw_irq_wrap`

## Requirements
- R1: After reset the interrupt output, both status words, both enable masks, the mode word and the soft-reset output are zero, and the PHY/UTMI word reads 0x0020_0000 (OTG disable set).
- R2: A read of offset 0x00 returns the nonzero revision constant (default 0x5542_0103); writes to that offset change nothing.
- R3: The endpoint status word (offset 0x30) latches transmit endpoint n in bit n and receive endpoint n in bit 16+n. Receive endpoint 0 never sets bit 16.
- R4: The core status word (offset 0x34) latches core event n in bit n for n = 0..8, with bit 8 being the VBUS-drive change event; bits 31:9 read zero.
- R5: An event latches whether or not it is enabled and stays set until software writes a 1 to its bit in the status word (write-one-to-clear); bits written with 0 are kept, and an event arriving in the same cycle as its clear leaves the bit set.
- R6: Writing ones to an enable-set register (0x38 endpoint, 0x3C core) enables those sources; writing ones to an enable-clear register (0x40 endpoint, 0x44 core) disables them; zero bits have no effect; both offsets of a pair read back the current mask; receive endpoint 0 cannot be enabled.
- R7: The interrupt output is registered: an enabled event sampled at one rising edge raises the output after the following rising edge, provided the end-of-interrupt path is armed; a latched but disabled event never raises it.
- R8: After the output has asserted, it stays low for any further pending events until any write to offset 0x24; if enabled status is pending when that write lands, the output rises on the next edge.
- R9: The output is level-type: it stays high while enabled status is pending and falls one cycle after the last enabled pending bit is cleared.
- R10: Writing bit 0 of the control register (0x14) produces a one-cycle pulse on the core soft-reset output; the bit self-clears and reads back 0.
- R11: The PHY/UTMI word (0xE0) is read/write and drives its value out; bit 21 drives the OTG-disable output and can be cleared by software.
- R12: Offset 0x18 returns the live VBUS-drive input level in bit 0.
- R13: The mode word (0xE8) is read/write and drives its value out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| tx_evt_i | input | 16 | Transmit endpoint event pulses |
| rx_evt_i | input | 16 | Receive endpoint event pulses |
| core_evt_i | input | 9 | Core event pulses, bit 8 VBUS-drive change |
| vbus_drv_i | input | 1 | Live VBUS-drive level |
| irq_o | output | 1 | Level interrupt |
| core_soft_rst_o | output | 1 | One-cycle soft reset to the core |
| otg_dis_o | output | 1 | OTG disable |
| phy_ctl_o | output | 32 | PHY/UTMI control word |
| mode_o | output | 32 | Mode word |

## Verification
The bench targets the end-of-interrupt hold-off. A design that re-armed on its own would raise the line again for a fresh event before the acknowledge write, and one that ignored a pending status on re-arm would never raise it after that write. It also drives an event into the same cycle as its own clear: a design that let the clear win would lose that event. Receive endpoint 0 is pulsed and its enable written, which catches a packing off by one bit or a missing mask. The bench also counts the exact edge on which the output rises and falls, which exposes a missing or extra register stage.

// File: rtl/usbw_pkg.sv
package usbw_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_REV      = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_CTRL     = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_LIVE     = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_EOI      = 12'h024;
    localparam logic [ADDR_W-1:0] OFS_EP_STAT  = 12'h030;
    localparam logic [ADDR_W-1:0] OFS_CO_STAT  = 12'h034;
    localparam logic [ADDR_W-1:0] OFS_EP_ESET  = 12'h038;
    localparam logic [ADDR_W-1:0] OFS_CO_ESET  = 12'h03C;
    localparam logic [ADDR_W-1:0] OFS_EP_ECLR  = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_CO_ECLR  = 12'h044;
    localparam logic [ADDR_W-1:0] OFS_PHY      = 12'h0E0;
    localparam logic [ADDR_W-1:0] OFS_MODE     = 12'h0E8;

    localparam int SRST_BIT    = 0;
    localparam int OTG_DIS_BIT = 21;
endpackage

// File: rtl/usbw_evt_bank.sv
module usbw_evt_bank #(
    parameter int           W    = 16,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] wdata_i,
    input  logic         stat_clr_i,
    input  logic         en_set_i,
    input  logic         en_clr_i,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] en_o,
    output logic         pend_o
);
    typedef struct packed {
        logic [W-1:0] stat;
        logic [W-1:0] en;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (en_set_i) bank_d.en = bank_d.en | (wdata_i & MASK);
        if (en_clr_i) bank_d.en = bank_d.en & ~wdata_i;
        if (stat_clr_i) bank_d.stat = bank_d.stat & ~wdata_i;
        // a new event outranks an acknowledge in the same cycle
        bank_d.stat = bank_d.stat | (evt_i & MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign stat_o = bank_q.stat;
    assign en_o   = bank_q.en;
    assign pend_o = |(bank_q.stat & bank_q.en);
endmodule

// File: rtl/usbw_eoi_gate.sv
module usbw_eoi_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    input  logic eoi_wr_i,
    output logic irq_o,
    output logic armed_o
);
    typedef struct packed {
        logic irq;
        logic armed;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d     = gate_q;
        // line may rise only when armed, then holds while pending
        gate_d.irq = pend_i & (gate_q.irq | gate_q.armed);
        if (eoi_wr_i)                    gate_d.armed = 1'b1;
        else if (gate_q.armed && pend_i) gate_d.armed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= '{irq: 1'b0, armed: 1'b1};
        else        gate_q <= gate_d;
    end

    assign irq_o   = gate_q.irq;
    assign armed_o = gate_q.armed;
endmodule

// File: rtl/usbw_cfg_regs.sv
module usbw_cfg_regs
    import usbw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              ctrl_wr_i,
    input  logic              phy_wr_i,
    input  logic              mode_wr_i,
    output logic              srst_o,
    output logic [DATA_W-1:0] phy_o,
    output logic [DATA_W-1:0] mode_o
);
    localparam logic [DATA_W-1:0] PHY_RST = DATA_W'(1) << OTG_DIS_BIT;

    typedef struct packed {
        logic              srst;
        logic [DATA_W-1:0] phy;
        logic [DATA_W-1:0] mode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d      = cfg_q;
        cfg_d.srst = ctrl_wr_i & wdata_i[SRST_BIT];
        if (phy_wr_i)  cfg_d.phy  = wdata_i;
        if (mode_wr_i) cfg_d.mode = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{srst: 1'b0, phy: PHY_RST, mode: '0};
        else        cfg_q <= cfg_d;
    end

    assign srst_o = cfg_q.srst;
    assign phy_o  = cfg_q.phy;
    assign mode_o = cfg_q.mode;
endmodule

// File: rtl/usbw_irq_wrap.sv
module usbw_irq_wrap
    import usbw_pkg::*;
#(
    parameter int          N_EP   = 16,
    parameter int          CORE_W = 9,
    parameter logic [31:0] REV    = 32'h5542_0103
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_EP-1:0]   tx_evt_i,
    input  logic [N_EP-1:0]   rx_evt_i,
    input  logic [CORE_W-1:0] core_evt_i,
    input  logic              vbus_drv_i,
    output logic              irq_o,
    output logic              core_soft_rst_o,
    output logic              otg_dis_o,
    output logic [DATA_W-1:0] phy_ctl_o,
    output logic [DATA_W-1:0] mode_o
);
    localparam int EP_W = 2 * N_EP;
    // receive endpoint 0 has no event
    localparam logic [EP_W-1:0] EP_MASK = {{(N_EP-1){1'b1}}, 1'b0, {N_EP{1'b1}}};

    logic              wr;
    logic              eoi_wr;
    logic [EP_W-1:0]   ep_stat, ep_en;
    logic [CORE_W-1:0] co_stat, co_en;
    logic              ep_pend, co_pend, pend_any, armed;

    assign wr     = bus_sel & bus_wr;
    assign eoi_wr = wr && (bus_addr == OFS_EOI);

    usbw_evt_bank #(.W(EP_W), .MASK(EP_MASK)) u_ep (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      ({rx_evt_i, tx_evt_i}),
        .wdata_i    (bus_wdata[EP_W-1:0]),
        .stat_clr_i (wr && (bus_addr == OFS_EP_STAT)),
        .en_set_i   (wr && (bus_addr == OFS_EP_ESET)),
        .en_clr_i   (wr && (bus_addr == OFS_EP_ECLR)),
        .stat_o     (ep_stat),
        .en_o       (ep_en),
        .pend_o     (ep_pend)
    );

    usbw_evt_bank #(.W(CORE_W), .MASK({CORE_W{1'b1}})) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (core_evt_i),
        .wdata_i    (bus_wdata[CORE_W-1:0]),
        .stat_clr_i (wr && (bus_addr == OFS_CO_STAT)),
        .en_set_i   (wr && (bus_addr == OFS_CO_ESET)),
        .en_clr_i   (wr && (bus_addr == OFS_CO_ECLR)),
        .stat_o     (co_stat),
        .en_o       (co_en),
        .pend_o     (co_pend)
    );

    assign pend_any = ep_pend | co_pend;

    usbw_eoi_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_i   (pend_any),
        .eoi_wr_i (eoi_wr),
        .irq_o    (irq_o),
        .armed_o  (armed)
    );

    usbw_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wdata_i   (bus_wdata),
        .ctrl_wr_i (wr && (bus_addr == OFS_CTRL)),
        .phy_wr_i  (wr && (bus_addr == OFS_PHY)),
        .mode_wr_i (wr && (bus_addr == OFS_MODE)),
        .srst_o    (core_soft_rst_o),
        .phy_o     (phy_ctl_o),
        .mode_o    (mode_o)
    );

    assign otg_dis_o = phy_ctl_o[OTG_DIS_BIT];

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_REV:                  bus_rdata = REV;
            OFS_CTRL:                 bus_rdata[SRST_BIT] = core_soft_rst_o;
            OFS_LIVE:                 bus_rdata[0] = vbus_drv_i;
            OFS_EP_STAT:              bus_rdata[EP_W-1:0] = ep_stat;
            OFS_CO_STAT:              bus_rdata[CORE_W-1:0] = co_stat;
            OFS_EP_ESET, OFS_EP_ECLR: bus_rdata[EP_W-1:0] = ep_en;
            OFS_CO_ESET, OFS_CO_ECLR: bus_rdata[CORE_W-1:0] = co_en;
            OFS_PHY:                  bus_rdata = phy_ctl_o;
            OFS_MODE:                 bus_rdata = mode_o;
            default:                  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/usbw_irq_chk.sv
module usbw_irq_chk #(
    parameter int EPW = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           irq,
    input logic           pend,
    input logic           armed,
    input logic           eoi_wr,
    input logic           srst,
    input logic [EPW-1:0] ep_stat,
    input logic [EPW-1:0] ep_en
);
    localparam int RX0 = EPW / 2;

    a_r7_armed_pending_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && pend) |=> irq);

    a_r8_hold_off_until_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !irq && !eoi_wr) |=> !irq);

    a_r9_level_falls: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |=> !irq);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> !srst);

    a_r3_rx0_never_latched: assert property (@(posedge clk) disable iff (!rst_n)
        !ep_stat[RX0]);

    a_r6_rx0_never_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        !ep_en[RX0]);
endmodule

bind usbw_irq_wrap usbw_irq_chk #(.EPW(EP_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq_o),
    .pend    (pend_any),
    .armed   (armed),
    .eoi_wr  (eoi_wr),
    .srst    (core_soft_rst_o),
    .ep_stat (ep_stat),
    .ep_en   (ep_en)
);

// File: tb/sim_usbw_irq_wrap.sv
module sim_usbw_irq_wrap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] tx_evt = '0, rx_evt = '0;
    logic [8:0]  core_evt = '0;
    logic        vbus = 1'b0;
    logic        irq, srst, otg_dis;
    logic [31:0] phy_ctl, mode;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [31:0] rd;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    usbw_irq_wrap u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_evt_i(tx_evt), .rx_evt_i(rx_evt), .core_evt_i(core_evt),
        .vbus_drv_i(vbus), .irq_o(irq), .core_soft_rst_o(srst),
        .otg_dis_o(otg_dis), .phy_ctl_o(phy_ctl), .mode_o(mode)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] t, input logic [15:0] r, input logic [8:0] c);
        @(negedge clk);
        tx_evt = t; rx_evt = r; core_evt = c;
        @(negedge clk);
        tx_evt = '0; rx_evt = '0; core_evt = '0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 srst", {31'b0, srst}, 0);
        chk("R1 otg_dis", {31'b0, otg_dis}, 1);
        rd_reg(12'h030, rd); chk("R1 ep stat", rd, 0);
        rd_reg(12'h034, rd); chk("R1 core stat", rd, 0);
        rd_reg(12'h038, rd); chk("R1 ep en", rd, 0);
        rd_reg(12'h03C, rd); chk("R1 core en", rd, 0);
        rd_reg(12'h0E0, rd); chk("R1 phy", rd, 32'h0020_0000);
        rd_reg(12'h0E8, rd); chk("R1 mode", rd, 0);
    endtask

    task automatic t_rev;
        rd_reg(12'h000, rd); chk("R2 rev", rd, 32'h5542_0103);
        wr_reg(12'h000, 32'h0);
        rd_reg(12'h000, rd); chk("R2 rev after write", rd, 32'h5542_0103);
    endtask

    task automatic t_pack;
        pulse(16'h0008, 16'h0005, 9'h0);
        rd_reg(12'h030, rd); chk("R3 packing rx0 dropped", rd, 32'h0004_0008);
        wr_reg(12'h030, 32'hFFFF_FFFF);
        rd_reg(12'h030, rd); chk("R5 full clear", rd, 0);
        pulse(16'h0, 16'h0, 9'h100);
        rd_reg(12'h034, rd); chk("R4 vbus change bit8", rd, 32'h100);
        pulse(16'h0, 16'h0, 9'h1FF);
        rd_reg(12'h034, rd); chk("R4 all core bits", rd, 32'h1FF);
        // R5 partial clear
        wr_reg(12'h034, 32'h0000_000F);
        rd_reg(12'h034, rd); chk("R5 partial w1c", rd, 32'h1F0);
        // R5 event arriving with its own clear
        @(negedge clk);
        core_evt = 9'h001; bus_sel = 1'b1; bus_wr = 1'b1;
        bus_addr = 12'h034; bus_wdata = 32'h0000_0001;
        @(negedge clk);
        core_evt = '0; bus_sel = 1'b0; bus_wr = 1'b0;
        rd_reg(12'h034, rd); chk("R5 event beats clear", rd, 32'h1F1);
        wr_reg(12'h034, 32'hFFFF_FFFF);
    endtask

    task automatic t_enable;
        wr_reg(12'h038, 32'h0001_0003);
        rd_reg(12'h038, rd); chk("R6 set, rx0 refused", rd, 32'h3);
        rd_reg(12'h040, rd); chk("R6 read at clear offset", rd, 32'h3);
        wr_reg(12'h038, 32'h0);
        rd_reg(12'h038, rd); chk("R6 zero set ignored", rd, 32'h3);
        wr_reg(12'h040, 32'h1);
        rd_reg(12'h038, rd); chk("R6 clear bit0", rd, 32'h2);
        wr_reg(12'h040, 32'h0);
        rd_reg(12'h040, rd); chk("R6 zero clear ignored", rd, 32'h2);
        @(negedge clk); chk("R6 no irq yet", {31'b0, irq}, 0);
    endtask

    task automatic t_irq;
        // disabled source latches but stays silent
        pulse(16'h0001, 16'h0, 9'h0);
        @(negedge clk); @(negedge clk);
        chk("R7 disabled no irq", {31'b0, irq}, 0);
        rd_reg(12'h030, rd); chk("R5 latched while disabled", rd, 32'h1);
        wr_reg(12'h030, 32'h1);
        // enabled source: one register stage after the latch
        pulse(16'h0002, 16'h0, 9'h0);
        chk("R7 not yet after latch edge", {31'b0, irq}, 0);
        @(negedge clk);
        chk("R7 asserted", {31'b0, irq}, 1);
        // R9 level drops one cycle after clear
        wr_reg(12'h030, 32'h2);
        chk("R9 still high at clear edge", {31'b0, irq}, 1);
        @(negedge clk);
        chk("R9 dropped", {31'b0, irq}, 0);
        // R8 hold-off
        pulse(16'h0002, 16'h0, 9'h0);
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R8 no reassert before eoi", {31'b0, irq}, 0);
        wr_reg(12'h024, 32'h0);
        chk("R8 low at eoi edge", {31'b0, irq}, 0);
        @(negedge clk);
        chk("R8 reassert after eoi", {31'b0, irq}, 1);
        wr_reg(12'h030, 32'hFFFF_FFFF);
        @(negedge clk);
        wr_reg(12'h024, 32'h0);
        // core path
        wr_reg(12'h03C, 32'h100);
        pulse(16'h0, 16'h0, 9'h100);
        @(negedge clk);
        chk("R7 core vbus event irq", {31'b0, irq}, 1);
        wr_reg(12'h034, 32'h100);
        @(negedge clk);
        chk("R9 core clear drops", {31'b0, irq}, 0);
    endtask

    task automatic t_cfg;
        wr_reg(12'h014, 32'h1);
        chk("R10 pulse high", {31'b0, srst}, 1);
        @(negedge clk);
        chk("R10 self clear", {31'b0, srst}, 0);
        rd_reg(12'h014, rd); chk("R10 reads 0", rd, 0);
        wr_reg(12'h0E0, 32'h0000_0000);
        chk("R11 otg_dis cleared", {31'b0, otg_dis}, 0);
        rd_reg(12'h0E0, rd); chk("R11 phy readback", rd, 0);
        wr_reg(12'h0E0, 32'h0020_0042);
        chk("R11 phy out", phy_ctl, 32'h0020_0042);
        vbus = 1'b1;
        rd_reg(12'h018, rd); chk("R12 vbus high", rd, 1);
        vbus = 1'b0;
        rd_reg(12'h018, rd); chk("R12 vbus low", rd, 0);
        wr_reg(12'h0E8, 32'h0000_00A5);
        chk("R13 mode out", mode, 32'hA5);
        rd_reg(12'h0E8, rd); chk("R13 mode readback", rd, 32'hA5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_rev;
        t_pack;
        t_enable;
        t_irq;
        t_cfg;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc >= 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog got=%0d exp=<20000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule